// File: doc/BRIEF.md
# Bidirectional Control-Unit Selection Chain

This block models how a channel picks the control unit that will serve a start operation. The channel sends a 16-bit device address down a serial chain of `N_UNITS` control units. The upper byte of the address names the channel and the lower byte names the device. The selection walks out along the chain in physical order and then comes back toward the channel. Each unit owns a contiguous device-byte window and carries a priority flag. A high-priority unit only looks at the address on the way out. A low-priority unit only looks at it on the way back. The unit at the far end is visited once, at the turn, and it tests the address whatever its flag says.

The selection moves one hop per clock. The first unit to find the address in its window claims it. The block then reports the index of that unit with condition code 0. If the selection gets back to the channel with no claim, the block reports condition code 3. The same code results when the channel byte does not match this chain's channel number.

Because the walk goes out and back, the flags reorder priority. Take the unit at 1-based position i. It has rank i if it is high-priority and rank 2N−i if it is low-priority. The last unit always has rank N. The controller is a four-state machine:

- `ST_IDLE`: waiting.
- `ST_OUT`: outbound walk.
- `ST_IN`: inbound walk.
- `ST_FIN`: one-cycle completion.

Its transitions are:

- IDLE→OUT on a start request.
- OUT→OUT to the next unit when nothing claims.
- OUT→IN at the far end when nothing claims.
- OUT→FIN on a claim, or at the far end when there is only one unit.
- IN→IN to the previous unit when nothing claims.
- IN→FIN on a claim, or when the walk reaches unit 0 with no claim.
- FIN→IDLE always.

Top module: `csel_chain`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `hit_o` are 0, `unit_o` is 0 and `cc_o` is 0.
- R2: A start request is taken only when the block is idle. `busy_o` is 1 from the cycle after the start edge up to and including the cycle in which `done_o` is 1.
- R3: On the outbound pass, a high-priority unit claims the address when two things hold. First, `addr_i[15:8]` equals `CHAN_ID`. Second, `addr_i[7:0]` lies within that unit's inclusive window from `RANGE_LO` to `RANGE_HI`. Bit g of `PRIO_HIGH` set means unit g is high-priority.
- R4: A low-priority unit claims an in-window address only on the inbound pass, so units visited inbound are tried in descending index order.
- R5: The last unit (index N−1) is visited once, at the turn. It claims any in-window address whatever its flag, and so has rank N.
- R6: The winner is the claiming unit of lowest rank. The rank is i for a high unit and 2N−i for a low unit, with i being the 1-based position.
- R7: On a claim, `done_o` is 1 for exactly one cycle. That cycle follows the start edge by exactly rank clock edges. In it, `hit_o`=1, `unit_o` is the winner's index and `cc_o`=0.
- R8: With no claim, including a channel-byte mismatch, `done_o` comes 2N−1 edges after the start edge, with `hit_o`=0, `unit_o`=0 and `cc_o`=3.
- R9: A start request made while a selection is in progress has no effect. This includes the completion cycle. The result and the completion time of the running selection are unchanged.
- R10: `hit_o`, `unit_o` and `cc_o` keep their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| addr_i | input | 16 | Device address: channel byte [15:8], device byte [7:0] |
| busy_o | output | 1 | Selection in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | A unit accepted the selection |
| unit_o | output | IDX_W | Index of the accepting unit |
| cc_o | output | 2 | Condition code: 0 accepted, 3 no unit accepted |

## Verification
If the start edge is k, the completion pulse is due in the cycle after edge k+rank. For a miss it is due after edge k+2N−1. `busy_o` rises in the cycle after edge k, and the held result changes only in the completion cycle. The bench steps a behavioural model on the same edges. The model computes each unit's rank from its window and flag, and it counts down the hops. Every output is compared with the model at each falling edge, so an early or late pulse fails in the exact cycle where it goes wrong. Start pulses are also issued during the walk and in the completion cycle, to show that they change neither the timing nor the result.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OUT  = 2'd1,
        ST_IN   = 2'd2,
        ST_FIN  = 2'd3
    } csel_state_e;

    localparam logic [1:0] CC_ACCEPT = 2'd0;
    localparam logic [1:0] CC_NONE   = 2'd3;

endpackage

// File: rtl/csel_unit_match.sv
module csel_unit_match #(
    parameter logic [7:0] CHAN_ID = 8'h01,
    parameter logic [7:0] LO      = 8'h00,
    parameter logic [7:0] HI      = 8'hFF,
    parameter bit         HIGH    = 1'b1,
    parameter bit         IS_LAST = 1'b0
) (
    input  logic [15:0] addr,
    output logic        take_out,
    output logic        take_in
);
    logic in_window;

    always_comb begin
        in_window = (addr[15:8] == CHAN_ID) && (addr[7:0] >= LO) && (addr[7:0] <= HI);
        take_out  = in_window && (HIGH || IS_LAST);
        take_in   = in_window && (!HIGH || IS_LAST);
    end
endmodule

// File: rtl/csel_walker.sv
module csel_walker
    import csel_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [15:0]        addr_in,
    input  logic [N_UNITS-1:0] take_out,
    input  logic [N_UNITS-1:0] take_in,
    output logic [15:0]        addr_q,
    output logic               busy,
    output logic               done,
    output logic               hit,
    output logic [IDX_W-1:0]   unit,
    output logic [1:0]         cc
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_UNITS - 1);

    csel_state_e      state_q, state_n;
    logic [IDX_W-1:0] pos_q, pos_n;
    logic             win, miss;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
            if (state_q == ST_IDLE && start)
                addr_q <= addr_in;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        pos_n   = pos_q;
        win     = 1'b0;
        miss    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_OUT;
                    pos_n   = '0;
                end
            end
            ST_OUT: begin
                if (take_out[pos_q]) begin
                    win     = 1'b1;
                    state_n = ST_FIN;
                end else if (pos_q == LAST) begin
                    if (N_UNITS == 1) begin
                        miss    = 1'b1;
                        state_n = ST_FIN;
                    end else begin
                        state_n = ST_IN;
                        pos_n   = LAST - IDX_W'(1);
                    end
                end else begin
                    pos_n = pos_q + IDX_W'(1);
                end
            end
            ST_IN: begin
                if (take_in[pos_q]) begin
                    win     = 1'b1;
                    state_n = ST_FIN;
                end else if (pos_q == '0) begin
                    miss    = 1'b1;
                    state_n = ST_FIN;
                end else begin
                    pos_n = pos_q - IDX_W'(1);
                end
            end
            ST_FIN: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit  <= 1'b0;
            unit <= '0;
            cc   <= CC_ACCEPT;
        end else if (win) begin
            hit  <= 1'b1;
            unit <= pos_q;
            cc   <= CC_ACCEPT;
        end else if (miss) begin
            hit  <= 1'b0;
            unit <= '0;
            cc   <= CC_NONE;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FIN);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r8_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (cc == CC_NONE && unit == '0));
    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(addr_q));
    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_FIN) |=> ($stable(unit) && $stable(cc) && $stable(hit)));
    a_r5_no_inbound_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IN) |-> (pos_q != LAST));
    a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(pos_q) < N_UNITS));
endmodule

// File: rtl/csel_chain.sv
module csel_chain #(
    parameter int                     N_UNITS   = 4,
    parameter logic [7:0]             CHAN_ID   = 8'h01,
    parameter logic [N_UNITS*8-1:0]   RANGE_LO  = {8'h80, 8'h28, 8'h40, 8'h20},
    parameter logic [N_UNITS*8-1:0]   RANGE_HI  = {8'h8F, 8'h37, 8'h7F, 8'h2F},
    parameter logic [N_UNITS-1:0]     PRIO_HIGH = 4'b0010,
    parameter int                     IDX_W     = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      addr_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             hit_o,
    output logic [IDX_W-1:0] unit_o,
    output logic [1:0]       cc_o
);
    logic [15:0]        addr_q;
    logic [N_UNITS-1:0] take_out, take_in;

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        csel_unit_match #(
            .CHAN_ID (CHAN_ID),
            .LO      (RANGE_LO[g*8 +: 8]),
            .HI      (RANGE_HI[g*8 +: 8]),
            .HIGH    (PRIO_HIGH[g]),
            .IS_LAST (g == N_UNITS - 1)
        ) u_match (
            .addr     (addr_q),
            .take_out (take_out[g]),
            .take_in  (take_in[g])
        );
    end

    csel_walker #(
        .N_UNITS (N_UNITS),
        .IDX_W   (IDX_W)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .addr_in  (addr_i),
        .take_out (take_out),
        .take_in  (take_in),
        .addr_q   (addr_q),
        .busy     (busy_o),
        .done     (done_o),
        .hit      (hit_o),
        .unit     (unit_o),
        .cc       (cc_o)
    );
endmodule

// File: tb/sim_csel_chain.sv
`timescale 1ns/1ps
module sim_csel_chain;
    localparam int         N    = 4;
    localparam logic [7:0] CHAN = 8'h01;
    localparam int         IW   = 2;

    // bench-side view of the unit windows and flags (unit 0..3)
    int lo_t [N] = '{'h20, 'h40, 'h28, 'h80};
    int hi_t [N] = '{'h2F, 'h7F, 'h37, 'h8F};
    bit hi_p [N] = '{1'b0, 1'b1, 1'b0, 1'b0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [15:0]   addr_i = '0;
    logic          busy_o, done_o, hit_o;
    logic [IW-1:0] unit_o;
    logic [1:0]    cc_o;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // model state: 0 idle, 1 walking, 2 completion
    int phase = 0;
    int cnt = 0;
    bit p_hit = 0;
    int p_unit = 0;
    int p_cc = 0;
    bit m_hit = 0;
    int m_unit = 0;
    int m_cc = 0;

    always #2.5 clk = ~clk;

    csel_chain u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .hit_o(hit_o), .unit_o(unit_o), .cc_o(cc_o)
    );

    // behavioural reference, stepped on the same edges
    always @(posedge clk) begin
        if (rst_n) begin
            if (phase == 0 && start_i) begin
                int best;
                best   = 2 * N;
                p_hit  = 0;
                p_unit = 0;
                p_cc   = 3;
                for (int i = 0; i < N; i++) begin
                    int r;
                    bit inw;
                    inw = (addr_i[15:8] == CHAN) && (int'(addr_i[7:0]) >= lo_t[i]) && (int'(addr_i[7:0]) <= hi_t[i]);
                    r = (i == N - 1) ? N : (hi_p[i] ? i + 1 : 2 * N - (i + 1));
                    if (inw && r < best) begin
                        best = r; p_hit = 1; p_unit = i; p_cc = 0;
                    end
                end
                cnt   = p_hit ? best : 2 * N - 1;
                phase = 1;
            end else if (phase == 1) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    phase  = 2;
                    m_hit  = p_hit;
                    m_unit = p_unit;
                    m_cc   = p_cc;
                end
            end else if (phase == 2) begin
                phase = 0;
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 busy", int'(busy_o), int'(phase != 0));
            chk("R7 done", int'(done_o), int'(phase == 2));
            chk("R10 hit", int'(hit_o), int'(m_hit));
            chk("R6 unit", int'(unit_o), m_unit);
            chk("R8 cc", int'(cc_o), m_cc);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic sel(logic [15:0] a, string t);
        @(negedge clk);
        tag = t;
        start_i = 1'b1;
        addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        addr_i = 16'hFFFF;
        while (phase != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 hit", int'(hit_o), 0);
        chk("R1 unit", int'(unit_o), 0);
        chk("R1 cc", int'(cc_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        sel(16'h0145, "R3");   // high unit 1 claims outbound, rank 2
        sel(16'h0150, "R3");   // top of high window interior
        sel(16'h0125, "R4");   // only low unit 0: rank 7
        sel(16'h012A, "R4");   // units 0 and 2 both: inbound meets 2 first (rank 5)
        sel(16'h0137, "R6");   // upper edge of unit 2
        sel(16'h0120, "R6");   // lower edge of unit 0
        sel(16'h0185, "R5");   // last unit, low flag, rank 4
        sel(16'h018F, "R5");   // last unit window edge
        sel(16'h0190, "R8");   // no window: cc 3 after 7
        sel(16'h0225, "R8");   // channel byte mismatch
        sel(16'h0100, "R8");

        // R9: start during walk and during completion is ignored
        @(negedge clk);
        tag = "R9";
        start_i = 1'b1; addr_i = 16'h0125;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; addr_i = 16'h0145;
        @(negedge clk);
        start_i = 1'b0;
        while (phase != 2) @(negedge clk);
        start_i = 1'b1; addr_i = 16'h0185;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);

        // back-to-back request right after idle returns
        sel(16'h0160, "R7");
        sel(16'h012F, "R7");
        finish_run();
    end
endmodule